// File: doc/BRIEF.md
# I2C Register Slave with Burst Write

This block is an I2C target that gives a bus master access to a bank of 64 eight-bit configuration registers. It runs entirely in the system clock domain. SCL and SDA are oversampled through a synchronizer, and start, stop and clock edges are detected from the sampled lines. SDA is never driven high. The block only asks the pad to pull the line low, through `sda_pull`, and the pad or board supplies the pull-up. Clock stretching, general call and 10-bit addressing are not supported.

The 7-bit bus address is a fixed five-bit prefix (default `00100`) followed by two strap pins. A write transaction has the form: address byte with the direction bit at 0, then a register-address byte whose upper two bits must be zero, then any number of data bytes until stop. Each data byte lands in the register at the pointer, and the pointer then steps forward. A read transaction (direction bit 1) returns bytes starting at the pointer, and the pointer steps forward after every byte.

The whole register bank is presented in parallel on `reg_q` so that the rest of the chip can use the values as control. There is no streaming interface at the edge, so there is no back-pressure to state. The master can only be paced by its own SCL, because stretching is out of scope.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges (drives the ninth bit low) an address byte only when its upper seven bits equal {prefix `00100`, `addr_strap[1]`, `addr_strap[0]`]. The lowest bit is the direction: 0 means write and 1 means read.
- R2: After an address byte that does not match, the block leaves SDA released for the rest of the transaction and no register changes.
- R3: In a write, a register-address byte whose bits 7:6 are not both zero is not acknowledged. Later bytes in that transaction are also not acknowledged, and no register changes.
- R4: In a write, every data byte after the register address is acknowledged. Byte k (counting from 0) is stored in register (start address + k), MSB first, and appears on `reg_q[8*n +: 8]` for register n.
- R5: The register pointer is 6 bits wide and wraps from 63 to 0, for both burst writes and reads.
- R6: A read returns the register at the pointer, MSB first, and advances the pointer after each byte. A read with no register address sent first continues from where the pointer was left.
- R7: When the master does not acknowledge a read byte, the block stops driving data and SDA stays released until the next start.
- R8: A start or stop that arrives in the middle of a byte discards the partial byte and writes nothing. A start always begins a new address phase.
- R9: Reset clears every register to zero and releases SDA.
- R10: `sda_pull` changes only while the sampled SCL is low, and it is low after any stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired value) |
| addr_strap | input | 2 | Low two bits of the bus address |
| sda_pull | output | 1 | 1 asks the pad to pull SDA low; 0 releases it |
| reg_q | output | 512 | All 64 registers, register n at bits 8n+7:8n |

## Verification
A pointer that is off by one, or fails to wrap, shows up in two places: on `reg_q` as soon as the next burst byte is stored, and in the next read byte on the bus. The register-bank assertion catches it one clock after the store. A wrong state-machine state shows up as a wrong acknowledge bit within one byte time, or as SDA being pulled in a bit slot where the master expects it released. The scoreboard compares every read byte in the bit period in which it completes. Aborted bytes are checked by reading `reg_q` right after the stop or repeated start. A later full transaction then confirms that the address phase restarted cleanly.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_REG,
    S_WDAT,
    S_ACK,
    S_TX,
    S_MACK
  } xfer_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_regslave_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  xfer_state_t       state;
  xfer_state_t       ack_next;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              slot_full;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ack_next  <= S_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      slot_full <= 1'b0;
      sda_pull  <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ptr       <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state     <= S_DEV;
        bitcnt    <= '0;
        slot_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_det) begin
        state     <= S_IDLE;
        slot_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        unique case (state)
          S_DEV, S_REG, S_WDAT: begin
            if (scl_rise && !slot_full) begin
              shreg  <= shifted;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                slot_full <= 1'b1;
                if (state == S_WDAT) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shifted;
                  ptr     <= ptr + 1'b1;
                end
              end
            end else if (scl_fall && slot_full) begin
              slot_full <= 1'b0;
              bitcnt    <= '0;
              if (state == S_DEV) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_pull <= 1'b1;
                  state    <= S_ACK;
                  ack_next <= shreg[0] ? S_TX : S_REG;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_REG) begin
                if (shreg[BYTE_W-1:ADDR_W] == '0) begin
                  ptr      <= shreg[ADDR_W-1:0];
                  sda_pull <= 1'b1;
                  state    <= S_ACK;
                  ack_next <= S_WDAT;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sda_pull <= 1'b1;
                state    <= S_ACK;
                ack_next <= S_WDAT;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (ack_next == S_TX) begin
                shreg    <= rd_data;
                sda_pull <= ~rd_data[BYTE_W-1];
              end else begin
                sda_pull <= 1'b0;
              end
              state <= ack_next;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                state    <= S_MACK;
                ptr      <= ptr + 1'b1;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_pull <= ~shreg[BYTE_W-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (sda_s) state <= S_IDLE;
              else       slot_full <= 1'b1;
            end else if (scl_fall && slot_full) begin
              slot_full <= 1'b0;
              bitcnt    <= '0;
              shreg     <= rd_data;
              sda_pull  <= ~rd_data[BYTE_W-1];
              state     <= S_TX;
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [ADDR_W-1:0]             raddr,
  output logic [DATA_W-1:0]             rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] flat
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (we && waddr == ADDR_W'(g))      mem[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = mem[g];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter logic [4:0] DEV_PREFIX  = 5'b00100,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              scl_in,
  input  logic                              sda_in,
  input  logic [1:0]                        addr_strap,
  output logic                              sda_pull,
  output logic [(1<<ADDR_W)*BYTE_W-1:0]     reg_q
);
  logic scl_sync, sda_sync, scl_up, scl_dn, start_seen, stop_seen;
  logic              bank_we;
  logic [ADDR_W-1:0] bank_waddr;
  logic [BYTE_W-1:0] bank_wdata;
  logic [ADDR_W-1:0] cur_ptr;
  logic [BYTE_W-1:0] bank_rdata;
  logic [6:0]        dev_addr;

  assign dev_addr = {DEV_PREFIX, addr_strap};

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_up), .scl_fall(scl_dn),
    .start_det(start_seen), .stop_det(stop_seen)
  );

  i2c_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_up), .scl_fall(scl_dn),
    .start_det(start_seen), .stop_det(stop_seen), .sda_s(sda_sync),
    .dev_addr(dev_addr), .rd_data(bank_rdata), .sda_pull(sda_pull),
    .wr_en(bank_we), .wr_addr(bank_waddr), .wr_data(bank_wdata), .ptr(cur_ptr)
  );

  i2c_reg_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .waddr(bank_waddr),
    .wdata(bank_wdata), .raddr(cur_ptr), .rdata(bank_rdata), .flat(reg_q)
  );
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
  parameter int ADDR_W = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sda_pull,
  input logic                          scl_s,
  input logic                          stop_det,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [7:0]                    wr_data,
  input logic [ADDR_W-1:0]             ptr,
  input logic [(1<<ADDR_W)*8-1:0]      reg_q
);
  logic [ADDR_W-1:0] next_slot;
  assign next_slot = wr_addr + 1'b1;

  // R9: reset releases SDA
  a_r9_reset_release: assert property (@(posedge clk) !rst_n |=> !sda_pull);

  // R10: pull only changes while SCL is low
  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  // R10: released after stop
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R4: stored byte shows on the register outputs
  a_r4_store_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg_q[$past(wr_addr)*8 +: 8] == $past(wr_data));

  // R5: pointer steps with wrap as each byte is stored
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ptr == next_slot);
endmodule

bind i2c_regslave i2c_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_s(scl_sync),
  .stop_det(stop_seen), .wr_en(bank_we), .wr_addr(bank_waddr),
  .wr_data(bank_wdata), .ptr(cur_ptr), .reg_q(reg_q)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam int Q = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_pull;
  logic [511:0] reg_q;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  event rx_ev;
  logic [7:0] rx_byte;

  assign sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regslave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .reg_q(reg_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int n);
    return reg_q[n*8 +: 8];
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic read_byte(input logic mack);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!mack);
    rx_byte = d;
    -> rx_ev;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) check("R6 unexpected read byte", 32'(rx_byte), 32'hFFFF);
      else check("R6 read byte", 32'(rx_byte), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    repeat (5) @(negedge clk);
    check("R9 sda released in reset", 32'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 registers cleared", 32'(reg_q[255:0] | reg_q[511:256]), 0);

    // R1 R4: burst write at 5
    bus_start();
    send_byte(8'h24, ak); check("R1 address ack", 32'(ak), 1);
    send_byte(8'h05, ak); check("R4 reg address ack", 32'(ak), 1);
    send_byte(8'hAA, ak); check("R4 data ack", 32'(ak), 1);
    send_byte(8'hBB, ak);
    send_byte(8'hCC, ak);
    bus_stop();
    check("R4 reg5", 32'(rg(5)), 32'hAA);
    check("R4 reg6", 32'(rg(6)), 32'hBB);
    check("R4 reg7", 32'(rg(7)), 32'hCC);
    check("R10 released after stop", 32'(sda_pull), 0);

    // R2: other address
    bus_start();
    send_byte(8'h26, ak); check("R2 mismatch nack", 32'(ak), 0);
    send_byte(8'h05, ak); check("R2 no ack later", 32'(ak), 0);
    send_byte(8'h99, ak);
    bus_stop();
    check("R2 reg5 unchanged", 32'(rg(5)), 32'hAA);

    // R3: register address with high bits
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h45, ak); check("R3 bad reg address nack", 32'(ak), 0);
    send_byte(8'h77, ak); check("R3 data nack", 32'(ak), 0);
    bus_stop();
    check("R3 reg5 unchanged", 32'(rg(5)), 32'hAA);

    // R5: wrap on write
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h3F, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    bus_stop();
    check("R5 reg63", 32'(rg(63)), 32'h11);
    check("R5 wrap reg0", 32'(rg(0)), 32'h22);

    // R6 R5 R7: read across wrap
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h3F, ak);
    bus_start();
    send_byte(8'h25, ak); check("R1 read address ack", 32'(ak), 1);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h00);
    read_byte(1'b1);
    read_byte(1'b1);
    read_byte(1'b0);
    wq();
    check("R7 released after master nack", 32'(sda_pull), 0);
    bus_stop();

    // R6: pointer continues into next read
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h05, ak);
    bus_start();
    send_byte(8'h25, ak);
    exp_q.push_back(8'hAA); exp_q.push_back(8'hBB);
    read_byte(1'b1);
    read_byte(1'b0);
    bus_stop();
    bus_start();
    send_byte(8'h25, ak);
    exp_q.push_back(8'hCC);
    read_byte(1'b0);
    bus_stop();

    // R8: stop in middle of data byte
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h0A, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    check("R8 partial byte not stored", 32'(rg(10)), 0);

    // R8: start in middle of data byte, then fresh address phase
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h0C, ak);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    bus_start();
    check("R8 aborted partial not stored", 32'(rg(12)), 0);
    send_byte(8'h24, ak); check("R8 address after restart", 32'(ak), 1);
    send_byte(8'h0C, ak);
    send_byte(8'h5A, ak);
    bus_stop();
    check("R8 write after restart", 32'(rg(12)), 32'h5A);

    // R1: strap change
    strap = 2'b01;
    wq();
    bus_start();
    send_byte(8'h24, ak); check("R1 old address nack", 32'(ak), 0);
    bus_stop();
    bus_start();
    send_byte(8'h22, ak); check("R1 new address ack", 32'(ak), 1);
    send_byte(8'h14, ak);
    send_byte(8'h3C, ak);
    bus_stop();
    check("R1 write via new address", 32'(rg(20)), 32'h3C);

    wq();
    check("R6 all read bytes seen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule